// File: doc/BRIEF.md
# Indexed General-Purpose Strobe Port

This block gives each of two card sockets one general-purpose strobe pin. The pin can serve an outside latch or buffer, so that a few spare lines of board status can be read, or a few board controls (lamps, solenoids, eject motors) can be driven, through the controller's own register space. Software reaches every register through an index/data pair on a small ISA-style I/O bus. An address select bit picks either the index register or the data window. Active-low read and write pulses qualify each access, and bytes move on an 8-bit bus.

Each socket occupies two index values. The lower one (2Eh for the first socket, 6Eh for the second) holds that socket's extended index. The upper one (2Fh and 6Fh) is a data window whose target depends on the extended index. Extended index 0Bh opens the strobe control register, and 0Ah opens the external data port. The control register sets the strobe's active level and its output drive, and chooses whether it fires on reads of the external port, on writes to it, or on both. Bus reads of the port return the external input byte. Bus writes place the byte on an external output bus, which keeps that byte after the pulse ends.

Top module: `gps_strobe_port`

## Requirements
- R1: After reset the index register, both extended-index registers, both control registers and the external output bus are all zero. No strobe output enable is asserted.
- R2: A write with select 0 loads the index register, and a read with select 0 returns it.
- R3: With the index at 2Eh (first socket) or 6Eh (second socket), a data-window write loads that socket's extended index, and a data-window read returns it.
- R4: With the index at the socket's data window (2Fh or 6Fh) and extended index 0Bh, the control register is read and written. Only bits 5, 4, 3 and 2 are stored. Bits 7, 6, 1 and 0 read as zero.
- R5: With control bit 4 set and extended index 0Ah, a data-window write asserts that socket's strobe while the write pulse is low. The external output byte for that socket equals the written byte during the pulse and keeps that value afterwards.
- R6: With control bit 3 set and extended index 0Ah, a data-window read asserts that socket's strobe while the read pulse is low. The read returns that socket's external input byte.
- R7: The strobe is never active with no pulse present, during control-register accesses, or on an external-port access whose direction bit is clear.
- R8: Control bit 5 selects the active level of the strobe: 1 makes it high and 0 makes it low.
- R9: With control bit 2 at 0 (open-drain), the output enable is high only while the strobe is active, and the value is then the active level. With bit 2 at 1 (totem-pole), the enable is always high and the value is the inactive level when idle.
- R10: The two sockets keep separate extended-index, control and output-byte state, and an access to one never strobes the other.
- R11: Data-window reads return zero when the index matches no socket or the extended index is neither 0Ah nor 0Bh. Writes in those cases change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the index register, 1 the data window |
| bus_ior_n | input | 1 | Active-low read pulse |
| bus_iow_n | input | 1 | Active-low write pulse |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ext_rd_data | input | 16 | External input byte per socket (socket 0 in bits 7:0) |
| ext_wr_data | output | 16 | External output byte per socket (socket 0 in bits 7:0) |
| stb_val | output | 2 | Strobe output value per socket |
| stb_oe | output | 2 | Strobe output enable per socket |

## Verification
The hardest case to reach from the ports is the strobe pin's state in the middle of a qualifying pulse. Reaching it takes a chain of accesses: the index register, then the extended-index register, then the control register, then a return to the external port. Only then can the pulse itself be held. The stimulus uses a helper that runs this whole chain for one socket and leaves the data window on the external port. It then opens a pulse and samples the pins and both byte buses before the pulse closes. The second socket is set up between accesses to the first, to show that neither socket disturbs the other.

// File: rtl/gps_pkg.sv
package gps_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] XIDX_PORT = 8'h0A;
   localparam logic [BYTE_W-1:0] XIDX_CTRL = 8'h0B;
   localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'h3C;
   localparam int CB_POL   = 5;
   localparam int CB_ONWR  = 4;
   localparam int CB_ONRD  = 3;
   localparam int CB_TOTEM = 2;

   typedef struct packed {
      logic pol;
      logic on_wr;
      logic on_rd;
      logic totem;
   } stb_cfg_t;

   function automatic stb_cfg_t unpack_cfg(input logic [BYTE_W-1:0] r);
      stb_cfg_t c;
      c.pol   = r[CB_POL];
      c.on_wr = r[CB_ONWR];
      c.on_rd = r[CB_ONRD];
      c.totem = r[CB_TOTEM];
      return c;
   endfunction
endpackage

// File: rtl/gps_bus_front.sv
module gps_bus_front
   import gps_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_ior_n,
   input  logic              bus_iow_n,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] idx_q,
   output logic              rd_act,
   output logic              wr_act,
   output logic              wr_first
);
   logic wr_seen_q;

   assign rd_act   = ~bus_ior_n;
   assign wr_act   = ~bus_iow_n;
   assign wr_first = wr_act & ~wr_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_seen_q <= 1'b0;
         idx_q     <= '0;
      end else begin
         wr_seen_q <= wr_act;
         if (wr_first && !bus_sel)
            idx_q <= bus_wdata;
      end
   end
endmodule

// File: rtl/gps_strobe_drv.sv
module gps_strobe_drv
   import gps_pkg::*;
(
   input  stb_cfg_t cfg,
   input  logic     active,
   output logic     pin_val,
   output logic     pin_oe
);
   always_comb begin
      if (cfg.totem) begin
         pin_oe  = 1'b1;
         pin_val = active ? cfg.pol : ~cfg.pol;
      end else begin
         pin_oe  = active;
         pin_val = cfg.pol;
      end
   end
endmodule

// File: rtl/gps_socket.sv
module gps_socket
   import gps_pkg::*;
#(
   parameter logic [7:0] XREG_IDX = 8'h2E
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic [BYTE_W-1:0] idx_q,
   input  logic              rd_act,
   input  logic              wr_act,
   input  logic              wr_first,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic [BYTE_W-1:0] ext_in,
   output logic [BYTE_W-1:0] rd_part,
   output logic [BYTE_W-1:0] ext_out,
   output logic [BYTE_W-1:0] ctrl_q,
   output logic              stb_act,
   output logic              pin_val,
   output logic              pin_oe
);
   localparam logic [7:0] WIN_IDX = XREG_IDX + 8'd1;

   logic [BYTE_W-1:0] xidx_q;
   logic [BYTE_W-1:0] ext_q;
   logic              hit_x, hit_w, hit_port, hit_ctrl;
   stb_cfg_t          cfg;

   assign hit_x    = bus_sel && (idx_q == XREG_IDX);
   assign hit_w    = bus_sel && (idx_q == WIN_IDX);
   assign hit_port = hit_w && (xidx_q == XIDX_PORT);
   assign hit_ctrl = hit_w && (xidx_q == XIDX_CTRL);
   assign cfg      = unpack_cfg(ctrl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xidx_q <= '0;
         ctrl_q <= '0;
         ext_q  <= '0;
      end else begin
         if (wr_first && hit_x)
            xidx_q <= bus_wdata;
         if (wr_first && hit_ctrl)
            ctrl_q <= bus_wdata & CTRL_KEEP;
         if (wr_act && hit_port)
            ext_q <= bus_wdata;
      end
   end

   assign ext_out = (wr_act && hit_port) ? bus_wdata : ext_q;
   assign stb_act = hit_port && ((wr_act && cfg.on_wr) || (rd_act && cfg.on_rd));

   always_comb begin
      rd_part = '0;
      if (hit_x)
         rd_part = xidx_q;
      else if (hit_ctrl)
         rd_part = ctrl_q;
      else if (hit_port)
         rd_part = ext_in;
   end

   gps_strobe_drv u_drv (
      .cfg     (cfg),
      .active  (stb_act),
      .pin_val (pin_val),
      .pin_oe  (pin_oe)
   );
endmodule

// File: rtl/gps_strobe_port.sv
module gps_strobe_port
   import gps_pkg::*;
#(
   parameter int NUM_SOCK   = 2,
   parameter int DATA_W     = 8,
   parameter int IDX_BASE   = 'h2E,
   parameter int IDX_STRIDE = 'h40
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_sel,
   input  logic                       bus_ior_n,
   input  logic                       bus_iow_n,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [NUM_SOCK*DATA_W-1:0] ext_rd_data,
   output logic [NUM_SOCK*DATA_W-1:0] ext_wr_data,
   output logic [NUM_SOCK-1:0]        stb_val,
   output logic [NUM_SOCK-1:0]        stb_oe
);
   localparam int LAST_IDX = IDX_BASE + (NUM_SOCK - 1) * IDX_STRIDE + 1;

   initial begin
      assert (DATA_W == BYTE_W) else $error("DATA_W must be 8");
      assert (NUM_SOCK >= 1 && NUM_SOCK <= 4) else $error("NUM_SOCK out of range");
      assert (LAST_IDX <= 255) else $error("socket index range exceeds 8 bits");
      assert (IDX_STRIDE >= 2) else $error("sockets would overlap");
   end

   logic [DATA_W-1:0]          idx_q;
   logic                       rd_act, wr_act, wr_first;
   logic [DATA_W-1:0]          sock_rd [NUM_SOCK];
   logic [NUM_SOCK*DATA_W-1:0] ctrl_flat;
   logic [NUM_SOCK-1:0]        stb_act;

   gps_bus_front u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_ior_n (bus_ior_n),
      .bus_iow_n (bus_iow_n),
      .bus_wdata (bus_wdata),
      .idx_q     (idx_q),
      .rd_act    (rd_act),
      .wr_act    (wr_act),
      .wr_first  (wr_first)
   );

   for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
      localparam logic [7:0] SOCK_IDX = 8'(IDX_BASE + s * IDX_STRIDE);
      gps_socket #(.XREG_IDX(SOCK_IDX)) u_sock (
         .clk       (clk),
         .rst_n     (rst_n),
         .bus_sel   (bus_sel),
         .idx_q     (idx_q),
         .rd_act    (rd_act),
         .wr_act    (wr_act),
         .wr_first  (wr_first),
         .bus_wdata (bus_wdata),
         .ext_in    (ext_rd_data[s*DATA_W +: DATA_W]),
         .rd_part   (sock_rd[s]),
         .ext_out   (ext_wr_data[s*DATA_W +: DATA_W]),
         .ctrl_q    (ctrl_flat[s*DATA_W +: DATA_W]),
         .stb_act   (stb_act[s]),
         .pin_val   (stb_val[s]),
         .pin_oe    (stb_oe[s])
      );
   end

   always_comb begin
      logic [DATA_W-1:0] acc;
      acc = '0;
      for (int s = 0; s < NUM_SOCK; s++)
         acc = acc | sock_rd[s];
      bus_rdata = bus_sel ? acc : idx_q;
   end
endmodule

// File: rtl/gps_strobe_chk.sv
module gps_strobe_chk #(
   parameter int NUM_SOCK = 2,
   parameter int DATA_W   = 8
)(
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_ior_n,
   input logic                       bus_iow_n,
   input logic [NUM_SOCK*DATA_W-1:0] ctrl_flat,
   input logic [NUM_SOCK-1:0]        stb_act,
   input logic [NUM_SOCK-1:0]        stb_val,
   input logic [NUM_SOCK-1:0]        stb_oe,
   input logic [NUM_SOCK*DATA_W-1:0] ext_wr_data
);
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ior_n && bus_iow_n) |-> (stb_act == '0));

   a_r10_one_socket: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_act));

   a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_iow_n && $past(bus_iow_n)) |-> $stable(ext_wr_data));

   for (genvar s = 0; s < NUM_SOCK; s++) begin : g_chk
      a_r9_od_enable: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_flat[s*DATA_W + 2] |-> (stb_oe[s] == stb_act[s]));
      a_r9_totem_drive: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_flat[s*DATA_W + 2] |-> stb_oe[s]);
      a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
         stb_act[s] |-> (stb_oe[s] && (stb_val[s] == ctrl_flat[s*DATA_W + 5])));
   end
endmodule

bind gps_strobe_port gps_strobe_chk #(.NUM_SOCK(NUM_SOCK), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_ior_n   (bus_ior_n),
   .bus_iow_n   (bus_iow_n),
   .ctrl_flat   (ctrl_flat),
   .stb_act     (stb_act),
   .stb_val     (stb_val),
   .stb_oe      (stb_oe),
   .ext_wr_data (ext_wr_data)
);

// File: tb/tb_gps_strobe_port.sv
`timescale 1ns/1ps
module tb_gps_strobe_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_ior_n = 1'b1;
   logic        bus_iow_n = 1'b1;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] ext_rd_data = 16'hC35A;
   logic [15:0] ext_wr_data;
   logic [1:0]  stb_val, stb_oe;

   always #2 clk = ~clk;

   gps_strobe_port dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_ior_n(bus_ior_n),
      .bus_iow_n(bus_iow_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_rd_data(ext_rd_data), .ext_wr_data(ext_wr_data),
      .stb_val(stb_val), .stb_oe(stb_oe)
   );

   // field 0: read bus, 1: {oe[1:0], val[1:0]}, 2: external output bytes
   typedef struct {
      int          fld;
      logic [15:0] exp;
      string       rq;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    total = 0;
   int    bad = 0;
   bit    done = 0;

   function automatic logic [15:0] probe(int f);
      case (f)
         0:       return {8'h00, bus_rdata};
         1:       return {12'h000, stb_oe, stb_val};
         default: return ext_wr_data;
      endcase
   endfunction

   initial begin : monitor
      forever begin
         @(mon_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = q.pop_front();
            act = probe(it.fld);
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s field%0d actual=%h expected=%h", it.rq, it.fld, act, it.exp);
            end
         end
      end
   end

   task automatic expect_now(int f, logic [15:0] e, string rq);
      item_t it;
      it.fld = f; it.exp = e; it.rq = rq;
      q.push_back(it);
      -> mon_ev;
      #0.1;
   endtask

   task automatic io_open(bit is_wr, bit sel, logic [7:0] d);
      @(negedge clk);
      bus_sel = sel;
      bus_wdata = d;
      if (is_wr) bus_iow_n = 1'b0; else bus_ior_n = 1'b0;
      #0.5;
   endtask

   task automatic io_close();
      @(posedge clk);
      @(negedge clk);
      bus_iow_n = 1'b1;
      bus_ior_n = 1'b1;
      #0.5;
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      io_open(1'b1, sel, d);
      io_close();
   endtask

   task automatic rd_chk(bit sel, logic [7:0] e, string rq);
      io_open(1'b0, sel, 8'h00);
      expect_now(0, {8'h00, e}, rq);
      io_close();
   endtask

   // program control of socket s, leave extended index at the port, index at data window
   task automatic set_ctrl(int s, logic [7:0] v);
      logic [7:0] xi;
      xi = (s == 0) ? 8'h2E : 8'h6E;
      wr(0, xi); wr(1, 8'h0B); wr(0, xi + 8'd1); wr(1, v);
      wr(0, xi); wr(1, 8'h0A); wr(0, xi + 8'd1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R1: reset state
      expect_now(0, 16'h0000, "R1 index reset");
      expect_now(1, 16'h0000, "R1 no enable");
      expect_now(2, 16'h0000, "R1 ext out reset");
      rst_n = 1'b1;
      rd_chk(1, 8'h00, "R1 R11 xidx zero no match");
      // R2
      wr(0, 8'h37);
      rd_chk(0, 8'h37, "R2 index readback");
      // R3
      wr(0, 8'h2E); wr(1, 8'h0B);
      rd_chk(1, 8'h0B, "R3 xidx readback");
      // R4 reserved bits, R7 no strobe on ctrl access, R9 totem idle
      wr(0, 8'h2F);
      io_open(1'b1, 1'b1, 8'hFF);
      expect_now(1, 16'h0000, "R7 ctrl write no strobe");
      io_close();
      rd_chk(1, 8'h3C, "R4 reserved zero");
      expect_now(1, 16'h0004, "R9 totem idle inactive level");
      // R5, R8, R9 open-drain active-low write strobe
      set_ctrl(0, 8'h10);
      expect_now(1, 16'h0000, "R9 od idle no enable");
      io_open(1'b1, 1'b1, 8'h96);
      expect_now(1, 16'h0004, "R5 R8 write strobe low");
      expect_now(2, 16'h0096, "R5 byte during pulse");
      io_close();
      expect_now(1, 16'h0000, "R5 strobe ends");
      expect_now(2, 16'h0096, "R5 byte held");
      io_open(1'b0, 1'b1, 8'h00);
      expect_now(1, 16'h0000, "R7 read with bit3 clear");
      expect_now(0, 16'h005A, "R6 read data");
      io_close();
      // R6, R8 active-high read strobe, open drain
      set_ctrl(0, 8'h28);
      expect_now(1, 16'h0001, "R9 od idle value");
      io_open(1'b0, 1'b1, 8'h00);
      expect_now(1, 16'h0005, "R6 R8 read strobe high");
      expect_now(0, 16'h005A, "R6 ext input");
      io_close();
      io_open(1'b1, 1'b1, 8'h96);
      expect_now(1, 16'h0001, "R7 write with bit4 clear");
      io_close();
      // R9 totem active-high
      set_ctrl(0, 8'h2C);
      expect_now(1, 16'h0004, "R9 totem idle");
      io_open(1'b0, 1'b1, 8'h00);
      expect_now(1, 16'h0005, "R9 totem active");
      io_close();
      // R10 second socket
      wr(0, 8'h6E); wr(1, 8'h0A); wr(0, 8'h6F);
      io_open(1'b0, 1'b1, 8'h00);
      expect_now(0, 16'h00C3, "R10 socket B input");
      expect_now(1, 16'h0004, "R10 no cross strobe");
      io_close();
      wr(0, 8'h2E);
      rd_chk(1, 8'h0A, "R10 socket A xidx kept");
      set_ctrl(1, 8'h18);
      expect_now(1, 16'h0004, "R10 B od idle");
      io_open(1'b1, 1'b1, 8'h71);
      expect_now(1, 16'h000C, "R10 B write strobe");
      io_close();
      expect_now(2, 16'h7196, "R10 separate bytes");
      // R11 unmatched extended index and index
      wr(0, 8'h2E); wr(1, 8'h05); wr(0, 8'h2F); wr(1, 8'hFF);
      rd_chk(1, 8'h00, "R11 other xidx reads zero");
      expect_now(2, 16'h7196, "R11 write ignored ext");
      wr(0, 8'h10);
      rd_chk(1, 8'h00, "R11 unmatched index");
      wr(0, 8'h2E); wr(1, 8'h0B); wr(0, 8'h2F);
      rd_chk(1, 8'h2C, "R11 R4 ctrl unchanged");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule